// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative memory reference into a flat physical address. A request names an addressing mode and carries the current contents of the four segment registers (code, data, stack, extra), the two base registers, the two index registers, the instruction and stack pointers, and a 16-bit displacement. The mode decides which of these add up to a 16-bit effective offset and which segment is the default. The chosen segment value is shifted left by four bits and added to the offset to give a 20-bit physical address.

An optional segment override can replace the default segment. It has no effect on instruction fetch or on the destination of a string operation, because both of those always use a fixed segment.

Requests enter through a valid/ready port and results leave through a valid/ready port with a one-entry output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or whenever its content is being taken in the same cycle. A result stays on the output, unchanged, until `out_ready` takes it. The block therefore keeps full throughput when the consumer never stalls. Under back-pressure it never drops or reorders results.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address is (segment << 4) + offset. Segment 2222h with offset 0016h yields 22236h, and segment 1111h with offset 1232h yields 12342h.
- R2: Mode 0 (fetch) uses the instruction pointer as offset with the code segment. Segment IDs on `out_seg` are 0 = code, 1 = data, 2 = stack, 3 = extra.
- R3: Mode 1 uses SP, mode 7 uses BP + displacement, and modes 12 and 13 use BP + SI + displacement and BP + DI + displacement. All four default to the stack segment.
- R4: The following modes default to the data segment:
  - mode 2: displacement only
  - modes 3, 4 and 5: BX, SI and DI alone
  - mode 6: BX + displacement
  - modes 8 and 9: SI + displacement and DI + displacement
  - modes 10 and 11: BX + SI + displacement and BX + DI + displacement
- R5: The effective offset is the sum of its terms modulo 2^16, taken before the segment base is added. For example, FFF0h + 0020h + 0001h gives offset 0011h.
- R6: Mode 14 (string source) uses SI with the data segment. Mode 15 (string destination) uses DI with the extra segment.
- R7: When `in_ovr_en` is high, `in_ovr_seg` replaces the default segment in every mode except 0 and 15, which keep the code and extra segments.
- R8: An accepted request appears on `out_valid`, `out_addr` and `out_seg` one clock after acceptance. `in_ready` equals `!out_valid || out_ready`. A result held while `out_ready` is low stays stable.
- R9: After reset `out_valid` is low and `in_ready` is high.
- R10: The 20-bit sum wraps modulo 2^20, so segment FFFFh with offset 0010h yields 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_mode | input | 4 | Addressing mode code |
| in_ovr_en | input | 1 | Segment override enable |
| in_ovr_seg | input | 2 | Override segment ID |
| in_cs | input | 16 | Code segment value |
| in_ds | input | 16 | Data segment value |
| in_ss | input | 16 | Stack segment value |
| in_es | input | 16 | Extra segment value |
| in_bx | input | 16 | Base register BX |
| in_bp | input | 16 | Base pointer BP |
| in_si | input | 16 | Source index SI |
| in_di | input | 16 | Destination index DI |
| in_sp | input | 16 | Stack pointer |
| in_ip | input | 16 | Instruction pointer |
| in_disp | input | 16 | Displacement |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 20 | Physical address |
| out_seg | output | 2 | Segment ID used |

## Verification
Two events can fall in the same cycle: a new request can be accepted in the very cycle the held result is consumed, and an override can arrive with a mode whose segment is pinned. The bench provokes the first by streaming requests back to back while `out_ready` follows an irregular pattern. A scoreboard then confirms that every result arrives once and in order, and that a stalled result does not move. It provokes the second by raising the override on the fetch and string-destination modes next to overridable modes, and checks that only the latter change segment.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [3:0] {
    AM_FETCH    = 4'd0,
    AM_STK_TOP  = 4'd1,
    AM_DIRECT   = 4'd2,
    AM_IND_BX   = 4'd3,
    AM_IND_SI   = 4'd4,
    AM_IND_DI   = 4'd5,
    AM_BASE_BX  = 4'd6,
    AM_BASE_BP  = 4'd7,
    AM_IDX_SI   = 4'd8,
    AM_IDX_DI   = 4'd9,
    AM_BX_SI    = 4'd10,
    AM_BX_DI    = 4'd11,
    AM_BP_SI    = 4'd12,
    AM_BP_DI    = 4'd13,
    AM_STR_SRC  = 4'd14,
    AM_STR_DST  = 4'd15
  } addr_mode_e;

  typedef enum logic [2:0] {
    TA_ZERO = 3'd0,
    TA_BX   = 3'd1,
    TA_BP   = 3'd2,
    TA_SP   = 3'd3,
    TA_IP   = 3'd4
  } term_a_e;

  typedef enum logic [1:0] {
    TB_ZERO = 2'd0,
    TB_SI   = 2'd1,
    TB_DI   = 2'd2
  } term_b_e;

  typedef struct packed {
    seg_id_e dflt_seg;
    logic    pinned;
    term_a_e ta;
    term_b_e tb;
    logic    use_disp;
  } mode_ctl_t;

endpackage

// File: rtl/seg_mode_decode.sv
module seg_mode_decode
  import seg_addr_pkg::*;
(
  input  addr_mode_e mode,
  output mode_ctl_t  ctl
);

  always_comb begin
    ctl = '{dflt_seg: SEG_DATA, pinned: 1'b0, ta: TA_ZERO, tb: TB_ZERO, use_disp: 1'b0};
    unique case (mode)
      AM_FETCH:   begin ctl.dflt_seg = SEG_CODE;  ctl.pinned = 1'b1; ctl.ta = TA_IP; end
      AM_STK_TOP: begin ctl.dflt_seg = SEG_STACK; ctl.ta = TA_SP; end
      AM_DIRECT:  begin ctl.use_disp = 1'b1; end
      AM_IND_BX:  begin ctl.ta = TA_BX; end
      AM_IND_SI:  begin ctl.tb = TB_SI; end
      AM_IND_DI:  begin ctl.tb = TB_DI; end
      AM_BASE_BX: begin ctl.ta = TA_BX; ctl.use_disp = 1'b1; end
      AM_BASE_BP: begin ctl.dflt_seg = SEG_STACK; ctl.ta = TA_BP; ctl.use_disp = 1'b1; end
      AM_IDX_SI:  begin ctl.tb = TB_SI; ctl.use_disp = 1'b1; end
      AM_IDX_DI:  begin ctl.tb = TB_DI; ctl.use_disp = 1'b1; end
      AM_BX_SI:   begin ctl.ta = TA_BX; ctl.tb = TB_SI; ctl.use_disp = 1'b1; end
      AM_BX_DI:   begin ctl.ta = TA_BX; ctl.tb = TB_DI; ctl.use_disp = 1'b1; end
      AM_BP_SI:   begin ctl.dflt_seg = SEG_STACK; ctl.ta = TA_BP; ctl.tb = TB_SI; ctl.use_disp = 1'b1; end
      AM_BP_DI:   begin ctl.dflt_seg = SEG_STACK; ctl.ta = TA_BP; ctl.tb = TB_DI; ctl.use_disp = 1'b1; end
      AM_STR_SRC: begin ctl.tb = TB_SI; end
      AM_STR_DST: begin ctl.dflt_seg = SEG_EXTRA; ctl.pinned = 1'b1; ctl.tb = TB_DI; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/seg_offset_adder.sv
module seg_offset_adder
  import seg_addr_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  mode_ctl_t          ctl,
  input  logic [OFF_W-1:0]   bx,
  input  logic [OFF_W-1:0]   bp,
  input  logic [OFF_W-1:0]   sp,
  input  logic [OFF_W-1:0]   ip,
  input  logic [OFF_W-1:0]   si,
  input  logic [OFF_W-1:0]   di,
  input  logic [OFF_W-1:0]   disp,
  output logic [OFF_W-1:0]   offset
);

  logic [OFF_W-1:0] term_a;
  logic [OFF_W-1:0] term_b;
  logic [OFF_W-1:0] term_d;

  always_comb begin
    unique case (ctl.ta)
      TA_BX:   term_a = bx;
      TA_BP:   term_a = bp;
      TA_SP:   term_a = sp;
      TA_IP:   term_a = ip;
      default: term_a = '0;
    endcase
    unique case (ctl.tb)
      TB_SI:   term_b = si;
      TB_DI:   term_b = di;
      default: term_b = '0;
    endcase
    term_d = ctl.use_disp ? disp : '0;
    // Sum kept at OFF_W bits: carries out of the offset are discarded.
    offset = term_a + term_b + term_d;
  end

endmodule

// File: rtl/seg_base_select.sv
module seg_base_select #(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int ID_W   = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0][SEG_W-1:0] segs,
  input  logic [ID_W-1:0]               dflt_id,
  input  logic                          pinned,
  input  logic                          ovr_en,
  input  logic [ID_W-1:0]               ovr_id,
  output logic [ID_W-1:0]               eff_id,
  output logic [SEG_W-1:0]              seg_val
);

  logic [NUM_SEG-1:0][SEG_W-1:0] picked;

  assign eff_id = (ovr_en && !pinned) ? ovr_id : dflt_id;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_pick
    assign picked[g] = (eff_id == ID_W'(g)) ? segs[g] : '0;
  end

  always_comb begin
    seg_val = '0;
    for (int k = 0; k < NUM_SEG; k++) seg_val = seg_val | picked[k];
  end

endmodule

// File: rtl/seg_phys_adder.sv
module seg_phys_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  phys
);

  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] off_ext;

  assign base_ext = {seg_val, {SHIFT{1'b0}}};
  assign off_ext  = PA_W'(offset);
  assign phys     = base_ext + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_mode,
  input  logic             in_ovr_en,
  input  logic [1:0]       in_ovr_seg,
  input  logic [SEG_W-1:0] in_cs,
  input  logic [SEG_W-1:0] in_ds,
  input  logic [SEG_W-1:0] in_ss,
  input  logic [SEG_W-1:0] in_es,
  input  logic [OFF_W-1:0] in_bx,
  input  logic [OFF_W-1:0] in_bp,
  input  logic [OFF_W-1:0] in_si,
  input  logic [OFF_W-1:0] in_di,
  input  logic [OFF_W-1:0] in_sp,
  input  logic [OFF_W-1:0] in_ip,
  input  logic [OFF_W-1:0] in_disp,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  out_addr,
  output logic [1:0]       out_seg
);

  localparam int NUM_SEG = 4;

  mode_ctl_t               ctl;
  logic [OFF_W-1:0]        offset;
  logic [1:0]              eff_id;
  logic [SEG_W-1:0]        seg_val;
  logic [PA_W-1:0]         phys;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_bank;
  logic                    accept;

  assign seg_bank = {in_es, in_ss, in_ds, in_cs};

  seg_mode_decode u_dec (
    .mode (addr_mode_e'(in_mode)),
    .ctl  (ctl)
  );

  seg_offset_adder #(.OFF_W(OFF_W)) u_off (
    .ctl    (ctl),
    .bx     (in_bx),
    .bp     (in_bp),
    .sp     (in_sp),
    .ip     (in_ip),
    .si     (in_si),
    .di     (in_di),
    .disp   (in_disp),
    .offset (offset)
  );

  seg_base_select #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_sel (
    .segs    (seg_bank),
    .dflt_id (ctl.dflt_seg),
    .pinned  (ctl.pinned),
    .ovr_en  (in_ovr_en),
    .ovr_id  (in_ovr_seg),
    .eff_id  (eff_id),
    .seg_val (seg_val)
  );

  seg_phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_pa (
    .seg_val (seg_val),
    .offset  (offset),
    .phys    (phys)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_seg   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= phys;
        out_seg  <= eff_id;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_seg)); // R8

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R8

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !(out_valid && !out_ready) |=> !out_valid); // R8

  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 4'd0 |=> out_seg == 2'd0); // R2

  AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 4'd15 |=> out_seg == 2'd3); // R6

  AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_ovr_en && in_mode != 4'd0 && in_mode != 4'd15
      |=> out_seg == $past(in_ovr_seg)); // R7

endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic        in_ovr_en = 1'b0;
  logic [1:0]  in_ovr_seg = '0;
  logic [15:0] in_cs = '0, in_ds = '0, in_ss = '0, in_es = '0;
  logic [15:0] in_bx = '0, in_bp = '0, in_si = '0, in_di = '0;
  logic [15:0] in_sp = '0, in_ip = '0, in_disp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_addr;
  logic [1:0]  out_seg;

  always #5 clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_ovr_en(in_ovr_en), .in_ovr_seg(in_ovr_seg),
    .in_cs(in_cs), .in_ds(in_ds), .in_ss(in_ss), .in_es(in_es),
    .in_bx(in_bx), .in_bp(in_bp), .in_si(in_si), .in_di(in_di),
    .in_sp(in_sp), .in_ip(in_ip), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_seg(out_seg)
  );

  typedef struct {
    logic [19:0] addr;
    logic [1:0]  seg;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   bp_on = 1'b0;
  int   cyc = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference from the requirements: segment ID and offset per mode code.
  function automatic void model(input logic [3:0] m, input logic oe, input logic [1:0] os,
                                output logic [19:0] a, output logic [1:0] s);
    logic [15:0] off;
    logic [1:0]  dflt;
    logic [15:0] segv;
    case (m)
      4'd0:  begin dflt = 2'd0; off = in_ip; end
      4'd1:  begin dflt = 2'd2; off = in_sp; end
      4'd2:  begin dflt = 2'd1; off = in_disp; end
      4'd3:  begin dflt = 2'd1; off = in_bx; end
      4'd4:  begin dflt = 2'd1; off = in_si; end
      4'd5:  begin dflt = 2'd1; off = in_di; end
      4'd6:  begin dflt = 2'd1; off = in_bx + in_disp; end
      4'd7:  begin dflt = 2'd2; off = in_bp + in_disp; end
      4'd8:  begin dflt = 2'd1; off = in_si + in_disp; end
      4'd9:  begin dflt = 2'd1; off = in_di + in_disp; end
      4'd10: begin dflt = 2'd1; off = in_bx + in_si + in_disp; end
      4'd11: begin dflt = 2'd1; off = in_bx + in_di + in_disp; end
      4'd12: begin dflt = 2'd2; off = in_bp + in_si + in_disp; end
      4'd13: begin dflt = 2'd2; off = in_bp + in_di + in_disp; end
      4'd14: begin dflt = 2'd1; off = in_si; end
      default: begin dflt = 2'd3; off = in_di; end
    endcase
    s = (oe && m != 4'd0 && m != 4'd15) ? os : dflt;
    case (s)
      2'd0: segv = in_cs;
      2'd1: segv = in_ds;
      2'd2: segv = in_ss;
      default: segv = in_es;
    endcase
    a = {segv, 4'h0} + {4'h0, off};
  endfunction

  // Driver: inputs already set; raise valid, wait for acceptance, push expectation.
  task automatic send(input logic [3:0] m, input logic oe, input logic [1:0] os, input string tag);
    exp_t e;
    @(negedge clk);
    in_mode = m; in_ovr_en = oe; in_ovr_seg = os; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model(m, oe, os, e.addr, e.seg);
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic set_regs(input logic [15:0] cs, ds, ss, es, bx, bp, si, di, sp, ip, disp);
    in_cs = cs; in_ds = ds; in_ss = ss; in_es = es; in_bx = bx; in_bp = bp;
    in_si = si; in_di = di; in_sp = sp; in_ip = ip; in_disp = disp;
  endtask

  // Back-pressure pattern
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp_on ? ((cyc % 3) != 0) && ((cyc % 7) != 2) : 1'b1;
  end

  // Monitor: compare consumed results, and check held results do not move.
  bit          was_stall = 1'b0;
  logic [19:0] held_addr;
  logic [1:0]  held_seg;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (was_stall)
        check(out_valid && out_addr == held_addr && out_seg == held_seg,
              "R8 stalled result stable", {12'h0, out_addr}, {12'h0, held_addr});
      was_stall = out_valid && !out_ready;
      held_addr = out_addr;
      held_seg  = out_seg;
      check(in_ready == (!out_valid || out_ready), "R8 ready rule",
            {31'h0, in_ready}, {31'h0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", {12'h0, out_addr}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_addr == e.addr && out_seg == e.seg, e.tag,
                {10'h0, out_seg, out_addr}, {10'h0, e.seg, e.addr});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin : stim
    repeat (3) @(posedge clk);
    #2;
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R9 in_ready after reset", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: worked examples
    set_regs(16'h1111, 16'h2222, 16'h3000, 16'h4000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h1232, 16'h0016);
    send(4'd2, 1'b0, 2'd0, "R1 2222:0016 -> 22236");
    send(4'd0, 1'b0, 2'd0, "R1 R2 fetch 1111:1232 -> 12342");

    // R3 stack modes, R4 data modes, R6 string modes
    set_regs(16'h0100, 16'h0200, 16'h2526, 16'h0700, 16'h1000, 16'h0400, 16'h2000, 16'h0030, 16'h1100, 16'h0002, 16'h1234);
    send(4'd1,  1'b0, 2'd0, "R3 SP stack");
    send(4'd7,  1'b0, 2'd0, "R3 BP+disp stack");
    send(4'd12, 1'b0, 2'd0, "R3 BP+SI+disp stack");
    send(4'd13, 1'b0, 2'd0, "R3 BP+DI+disp stack");
    for (int m = 2; m <= 11; m++)
      if (m != 7) send(4'(m), 1'b0, 2'd0, "R4 data-default mode");
    send(4'd14, 1'b0, 2'd0, "R6 string source DS:SI");
    send(4'd15, 1'b0, 2'd0, "R6 string dest ES:DI");

    // R5: offset wraps before segment add
    set_regs(16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'hFFF0, 16'hFFFF, 16'h0020, 16'hFFFF, 16'h0, 16'h0, 16'h0001);
    send(4'd10, 1'b0, 2'd0, "R5 BX+SI+disp wraps to 0011");
    send(4'd13, 1'b0, 2'd0, "R5 BP+DI+disp wraps");

    // R10: 20-bit wrap
    set_regs(16'h0, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0010);
    send(4'd2, 1'b0, 2'd0, "R10 FFFF:0010 -> 00000");

    // R7: override on overridable modes, ignored on fetch and string dest
    set_regs(16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0055, 16'h0066, 16'h0077);
    send(4'd2,  1'b1, 2'd3, "R7 direct overridden to extra");
    send(4'd7,  1'b1, 2'd1, "R7 BP based overridden to data");
    send(4'd14, 1'b1, 2'd0, "R7 string source overridden to code");
    send(4'd0,  1'b1, 2'd2, "R7 fetch ignores override");
    send(4'd15, 1'b1, 2'd1, "R7 string dest ignores override");

    // R8: stream under back-pressure with varied operands
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++) begin
      lfsr = nxt(lfsr); in_cs = lfsr; lfsr = nxt(lfsr); in_ds = lfsr;
      lfsr = nxt(lfsr); in_ss = lfsr; lfsr = nxt(lfsr); in_es = lfsr;
      lfsr = nxt(lfsr); in_bx = lfsr; lfsr = nxt(lfsr); in_bp = lfsr;
      lfsr = nxt(lfsr); in_si = lfsr; lfsr = nxt(lfsr); in_di = lfsr;
      lfsr = nxt(lfsr); in_sp = lfsr; lfsr = nxt(lfsr); in_ip = lfsr;
      lfsr = nxt(lfsr); in_disp = lfsr;
      send(4'(i % 16), lfsr[3], lfsr[5:4], "R8 R7 streamed under back-pressure");
    end
    bp_on = 1'b0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule